// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block controls the movement of data between a working SRAM array and its shadow nonvolatile copy. Stores can be requested from three places: an active-low hardware request pin, a decoded software command, and a supply comparator whose falling edge asks for an automatic store. Recalls come from power-up, meaning any period with the supply below the switch threshold, and from a software command. The block sequences each transfer as counted phases. A store erases and then programs. A recall clears and then copies. The current phase goes to a simple array model, and the block raises a one-cycle done strobe when the transfer ends.

The block sits between the host strobes and the array. It passes host reads and writes through as array enables, and it withholds them during transfers and while the supply is low. It records whether any write has happened since the last nonvolatile cycle, and it holds an auto-store enable bit. It drives an active-low busy output, in the manner of an open-drain line, for the whole of every store. There is no streaming data path. Every pin is a plain level or a one-cycle pulse, and a software command given while the block is not idle is simply dropped.

Top module: `nvshadow_sequencer`

## Requirements
- R1: In reset, `auto_en`=1, `dirty`=0, `busy_n`=1 and `status`=0. At the first clock edge after reset is released with `sup_ok`=1, a power-up recall begins.
- R2: In idle, `arr_wr_en` follows (`host_ce_n`=0 and `host_we_n`=0) and `arr_rd_en` follows (`host_ce_n`=0 and `host_we_n`=1), in the same cycle. Both enables are 0 in every cycle where `status` is 2 or 3.
- R3: `dirty` becomes 1 in the cycle after any cycle with `arr_wr_en`=1. It is 0 in the cycle in which a store or a recall reports `xfer_done`.
- R4: `busy_n` is 0 for exactly ERASE_CYC+PROG_CYC cycles of every store, whatever started it. It returns to 1 in the cycle where `xfer_done`=1 and `xfer_store`=1.
- R5: `nv_phase` encodes 0 none, 1 erase, 2 program, 3 clear, 4 copy. A store runs ERASE_CYC cycles of erase and then PROG_CYC cycles of program. A recall runs CLEAR_CYC cycles of clear, then PU_COPY_CYC (power-up) or SW_COPY_CYC (software) cycles of copy. The done strobe lasts one cycle, and `xfer_store` is 1 for a store and 0 for a recall.
- R6: With `dirty`=1, `hw_req_n`=0 in idle opens a grace window of GRACE_CYC cycles (`status`=1), followed by a store. With `dirty`=0, the request is ignored.
- R7: During the grace window reads still pass. A write that was active when the request was taken continues until its strobes end. Any new write is blocked.
- R8: If `hw_req_n` is still 0 when a store ends, the block stays locked with `status`=2, `busy_n`=1 and no host access. It returns to idle in the cycle after `hw_req_n` goes high.
- R9: Software commands (`sw_cmd_valid`, with `sw_cmd_op`: 0 store, 1 recall, 2 auto-store off, 3 auto-store on) are accepted only in idle with `sup_ok`=1 and are otherwise dropped. A software store runs even when `dirty`=0.
- R10: A falling edge on `sup_ok` starts a store at the next edge only if `auto_en`=1 and `dirty`=1. While `sup_ok`=0, writes and all hardware or software requests are blocked. A recall is latched and then runs, with power-up copy length, once `sup_ok` returns to 1.
- R11: When requests arrive together the priority is power-up recall, then automatic store, then hardware store, then software command.
- R12: If a write strobe pair is active when reset ends or when a store or recall completes, writes stay blocked until `host_ce_n` or `host_we_n` has gone high and then low again.
- R13: `status` encodes 0 idle, 1 grace window, 2 store (erase, program, release wait), 3 recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_ok | input | 1 | Supply comparator, 1 when above switch threshold |
| hw_req_n | input | 1 | Hardware store request, active low |
| sw_cmd_valid | input | 1 | Decoded software command pulse |
| sw_cmd_op | input | 2 | Software command code |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| arr_wr_en | output | 1 | Gated array write enable |
| arr_rd_en | output | 1 | Gated array read enable |
| busy_n | output | 1 | Store busy, active low |
| nv_phase | output | 3 | Transfer phase to the array model |
| xfer_done | output | 1 | One-cycle transfer completion strobe |
| xfer_store | output | 1 | Completed transfer was a store |
| status | output | 2 | Sequencer status |
| dirty | output | 1 | Write since last nonvolatile cycle |
| auto_en | output | 1 | Automatic store enable |

## Verification
The access enables are combinational, so they are checked one time unit after the strobes are driven at the falling clock edge. `status`, `nv_phase` and `busy_n` change on the first rising edge after a request and are read at the following falling edge. `dirty` is checked one cycle after a write. The done strobe is checked at the first falling edge where the measured phase status has ended. Phase lengths are measured by counting the falling edges during which `status` or `busy_n` holds its value, and each count is compared with the sum of the relevant cycle parameters.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_GRACE, S_ERASE, S_PROG, S_CLEAR, S_COPY, S_RELWAIT
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_NONE = 3'd0, PH_ERASE = 3'd1, PH_PROG = 3'd2, PH_CLEAR = 3'd3, PH_COPY = 3'd4
  } nv_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0, ST_GRACE = 2'd1, ST_STORE = 2'd2, ST_RECALL = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    RQ_NONE, RQ_PU_RCL, RQ_AUTO_ST, RQ_HW_ST, RQ_SW_ST, RQ_SW_RCL, RQ_AE_OFF, RQ_AE_ON
  } req_e;

  localparam logic [1:0] OP_STORE    = 2'd0;
  localparam logic [1:0] OP_RECALL   = 2'd1;
  localparam logic [1:0] OP_AUTO_OFF = 2'd2;
  localparam logic [1:0] OP_AUTO_ON  = 2'd3;
endpackage

// File: rtl/nvseq_arbiter.sv
module nvseq_arbiter
  import nvseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_ok,
  input  logic       hw_req_n,
  input  logic       sw_cmd_valid,
  input  logic [1:0] sw_cmd_op,
  input  logic       dirty,
  input  logic       idle,
  output req_e       req,
  output logic       auto_en
);
  logic sup_q, pu_pend, pf_pend, pf_evt, auto_ok;

  assign pf_evt  = sup_q & ~sup_ok;
  assign auto_ok = auto_en & dirty;

  // fixed priority: power-up recall, supply-loss store, pin store, software
  always_comb begin
    req = RQ_NONE;
    if (pu_pend && sup_ok) begin
      req = RQ_PU_RCL;
    end else if ((pf_pend || pf_evt) && auto_ok) begin
      req = RQ_AUTO_ST;
    end else if (!hw_req_n && sup_ok && dirty) begin
      req = RQ_HW_ST;
    end else if (sw_cmd_valid && sup_ok) begin
      case (sw_cmd_op)
        OP_STORE:    req = RQ_SW_ST;
        OP_RECALL:   req = RQ_SW_RCL;
        OP_AUTO_OFF: req = RQ_AE_OFF;
        default:     req = RQ_AE_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q   <= 1'b0;
      pu_pend <= 1'b1;
      pf_pend <= 1'b0;
      auto_en <= 1'b1;
    end else begin
      sup_q <= sup_ok;
      if (!sup_ok) pu_pend <= 1'b1;
      else if (idle && req == RQ_PU_RCL) pu_pend <= 1'b0;
      // in idle a pending supply-loss event is either taken or dropped
      if (idle) pf_pend <= 1'b0;
      else if (pf_evt) pf_pend <= 1'b1;
      if (idle && req == RQ_AE_OFF) auto_en <= 1'b0;
      else if (idle && req == RQ_AE_ON) auto_en <= 1'b1;
    end
  end

  a_r10_no_ext_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok && idle) |=> !(req == RQ_HW_ST || req == RQ_SW_ST) || $past(sup_ok) == 1'b0 && sup_ok)
    else $error("a_r10_no_ext_low");
endmodule

// File: rtl/nvseq_access_gate.sv
module nvseq_access_gate
  import nvseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_ok,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  input  seq_state_e state,
  input  logic       grace_start,
  input  logic       fin,
  output logic       arr_wr_en,
  output logic       arr_rd_en,
  output logic       dirty
);
  logic wr_cond, rd_cond, open_st, grace_st, wr_hold, inflight;

  assign wr_cond  = ~host_ce_n & ~host_we_n;
  assign rd_cond  = ~host_ce_n & host_we_n;
  assign open_st  = (state == S_IDLE);
  assign grace_st = (state == S_GRACE);

  assign arr_wr_en = wr_cond & sup_ok & ~wr_hold & (open_st | (grace_st & inflight));
  assign arr_rd_en = rd_cond & (open_st | grace_st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty    <= 1'b0;
      wr_hold  <= 1'b1;
      inflight <= 1'b0;
    end else begin
      if (fin) dirty <= 1'b0;
      else if (arr_wr_en) dirty <= 1'b1;
      // a strobe pair held across a transfer end must be re-issued
      wr_hold  <= wr_cond & (wr_hold | fin);
      inflight <= grace_start ? arr_wr_en : (grace_st & inflight & wr_cond);
    end
  end

  a_r7_grace_no_new_write: assert property (@(posedge clk) disable iff (!rst_n)
    (grace_st && arr_wr_en) |-> $past(arr_wr_en))
    else $error("a_r7_grace_no_new_write");

  a_r3_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && !fin) |=> dirty)
    else $error("a_r3_dirty_after_write");

  a_r12_rearm_after_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && wr_cond) |=> !arr_wr_en)
    else $error("a_r12_rearm_after_transfer");
endmodule

// File: rtl/nvseq_engine.sv
module nvseq_engine
  import nvseq_pkg::*;
#(
  parameter int GRACE_CYC   = 6,
  parameter int ERASE_CYC   = 4,
  parameter int PROG_CYC    = 6,
  parameter int CLEAR_CYC   = 3,
  parameter int SW_COPY_CYC = 5,
  parameter int PU_COPY_CYC = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  req_e       req,
  input  logic       hw_req_n,
  output seq_state_e state,
  output logic       grace_start,
  output logic       fin_store,
  output logic       fin_recall,
  output status_e    status,
  output nv_phase_e  phase,
  output logic       busy_n,
  output logic       xfer_done,
  output logic       xfer_store
);
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LONGEST = imax(imax(imax(GRACE_CYC, ERASE_CYC), imax(PROG_CYC, CLEAR_CYC)),
                                imax(SW_COPY_CYC, PU_COPY_CYC));
  localparam int CW = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t L_GRACE = cnt_t'(GRACE_CYC - 1);
  localparam cnt_t L_ERASE = cnt_t'(ERASE_CYC - 1);
  localparam cnt_t L_PROG  = cnt_t'(PROG_CYC - 1);
  localparam cnt_t L_CLEAR = cnt_t'(CLEAR_CYC - 1);
  localparam cnt_t L_SWCP  = cnt_t'(SW_COPY_CYC - 1);
  localparam cnt_t L_PUCP  = cnt_t'(PU_COPY_CYC - 1);

  seq_state_e nxt;
  cnt_t       cnt, cnt_nxt;
  logic       long_rcl, long_nxt, zero;

  assign zero = (cnt == '0);

  always_comb begin
    nxt         = state;
    cnt_nxt     = zero ? cnt : cnt - cnt_t'(1);
    long_nxt    = long_rcl;
    grace_start = 1'b0;
    fin_store   = 1'b0;
    fin_recall  = 1'b0;
    case (state)
      S_IDLE: begin
        case (req)
          RQ_PU_RCL:  begin nxt = S_CLEAR; cnt_nxt = L_CLEAR; long_nxt = 1'b1; end
          RQ_SW_RCL:  begin nxt = S_CLEAR; cnt_nxt = L_CLEAR; long_nxt = 1'b0; end
          RQ_AUTO_ST,
          RQ_SW_ST:   begin nxt = S_ERASE; cnt_nxt = L_ERASE; end
          RQ_HW_ST:   begin nxt = S_GRACE; cnt_nxt = L_GRACE; grace_start = 1'b1; end
          default:    ;
        endcase
      end
      S_GRACE: if (zero) begin nxt = S_ERASE; cnt_nxt = L_ERASE; end
      S_ERASE: if (zero) begin nxt = S_PROG; cnt_nxt = L_PROG; end
      S_PROG: if (zero) begin
        fin_store = 1'b1;
        nxt = hw_req_n ? S_IDLE : S_RELWAIT;
      end
      S_CLEAR: if (zero) begin nxt = S_COPY; cnt_nxt = long_rcl ? L_PUCP : L_SWCP; end
      S_COPY: if (zero) begin fin_recall = 1'b1; nxt = S_IDLE; end
      S_RELWAIT: if (hw_req_n) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      long_rcl   <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_store <= 1'b0;
    end else begin
      state      <= nxt;
      cnt        <= cnt_nxt;
      long_rcl   <= long_nxt;
      xfer_done  <= fin_store | fin_recall;
      xfer_store <= fin_store;
    end
  end

  always_comb begin
    busy_n = 1'b1;
    status = ST_IDLE;
    phase  = PH_NONE;
    case (state)
      S_GRACE:   status = ST_GRACE;
      S_ERASE:   begin status = ST_STORE;  phase = PH_ERASE; busy_n = 1'b0; end
      S_PROG:    begin status = ST_STORE;  phase = PH_PROG;  busy_n = 1'b0; end
      S_RELWAIT: status = ST_STORE;
      S_CLEAR:   begin status = ST_RECALL; phase = PH_CLEAR; end
      S_COPY:    begin status = ST_RECALL; phase = PH_COPY;  end
      default:   ;
    endcase
  end

  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done)
    else $error("a_r5_done_one_cycle");

  a_r4_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (xfer_done && xfer_store))
    else $error("a_r4_busy_release");

  a_r8_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RELWAIT && !hw_req_n) |=> (state == S_RELWAIT))
    else $error("a_r8_hold_until_release");

  a_r5_program_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && $past(state) != S_PROG) |-> ($past(state) == S_ERASE))
    else $error("a_r5_program_after_erase");
endmodule

// File: rtl/nvshadow_sequencer.sv
module nvshadow_sequencer
  import nvseq_pkg::*;
#(
  parameter int GRACE_CYC   = 6,
  parameter int ERASE_CYC   = 4,
  parameter int PROG_CYC    = 6,
  parameter int CLEAR_CYC   = 3,
  parameter int SW_COPY_CYC = 5,
  parameter int PU_COPY_CYC = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_ok,
  input  logic       hw_req_n,
  input  logic       sw_cmd_valid,
  input  logic [1:0] sw_cmd_op,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  output logic       arr_wr_en,
  output logic       arr_rd_en,
  output logic       busy_n,
  output logic [2:0] nv_phase,
  output logic       xfer_done,
  output logic       xfer_store,
  output logic [1:0] status,
  output logic       dirty,
  output logic       auto_en
);
  req_e       req;
  seq_state_e state;
  status_e    st_w;
  nv_phase_e  ph_w;
  logic       grace_start, fin_store, fin_recall;

  nvseq_arbiter u_arb (
    .clk, .rst_n, .sup_ok, .hw_req_n, .sw_cmd_valid, .sw_cmd_op,
    .dirty, .idle(state == S_IDLE), .req, .auto_en
  );

  nvseq_engine #(
    .GRACE_CYC(GRACE_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .CLEAR_CYC(CLEAR_CYC), .SW_COPY_CYC(SW_COPY_CYC), .PU_COPY_CYC(PU_COPY_CYC)
  ) u_eng (
    .clk, .rst_n, .req, .hw_req_n, .state, .grace_start, .fin_store, .fin_recall,
    .status(st_w), .phase(ph_w), .busy_n, .xfer_done, .xfer_store
  );

  nvseq_access_gate u_gate (
    .clk, .rst_n, .sup_ok, .host_ce_n, .host_we_n, .state, .grace_start,
    .fin(fin_store | fin_recall), .arr_wr_en, .arr_rd_en, .dirty
  );

  assign status   = st_w;
  assign nv_phase = ph_w;

  a_r2_locked_during_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2 || status == 2'd3) |-> (!arr_wr_en && !arr_rd_en))
    else $error("a_r2_locked_during_transfer");

  a_r3_clean_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !dirty)
    else $error("a_r3_clean_at_done");

  a_r10_no_write_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |-> !arr_wr_en)
    else $error("a_r10_no_write_low_supply");
endmodule

// File: tb/nvshadow_sequencer_test.sv
module nvshadow_sequencer_test;
  localparam int G = 6, E = 4, P = 6, C = 3, SWC = 5, PUC = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup_ok = 1'b1, hw_req_n = 1'b1, sw_cmd_valid = 1'b0;
  logic [1:0] sw_cmd_op = 2'd0;
  logic host_ce_n = 1'b1, host_we_n = 1'b1;
  logic arr_wr_en, arr_rd_en, busy_n, xfer_done, xfer_store, dirty, auto_en;
  logic [2:0] nv_phase;
  logic [1:0] status;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  nvshadow_sequencer #(.GRACE_CYC(G), .ERASE_CYC(E), .PROG_CYC(P), .CLEAR_CYC(C),
    .SW_COPY_CYC(SWC), .PU_COPY_CYC(PUC)) uut (.*);

  // {host_ce_n, host_we_n, expected wr, expected rd}
  localparam logic [3:0] ACC_VEC [6] = '{4'b1100, 4'b0101, 4'b0010, 4'b1000, 4'b0010, 4'b1100};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nedge();
    @(negedge clk);
  endtask

  task automatic count_status(int st, output int n, output int rd_seen, output int bz_seen);
    n = 0; rd_seen = 0; bz_seen = 0;
    while (status == 2'(st) && n < 2000) begin
      n++;
      if (arr_rd_en) rd_seen++;
      if (!busy_n) bz_seen++;
      nedge();
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!busy_n && n < 2000) begin n++; nedge(); end
  endtask

  task automatic write_once();
    host_ce_n = 0; host_we_n = 0; nedge();
    host_ce_n = 1; host_we_n = 1; nedge();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, rd, bz, k;
    // reset state
    repeat (3) nedge();
    chk("R1 auto_en in reset", auto_en, 1);
    chk("R1 dirty in reset", dirty, 0);
    chk("R1 busy_n in reset", busy_n, 1);
    chk("R13 status in reset", status, 0);
    rst_n = 1; host_ce_n = 0; host_we_n = 1;
    nedge();
    chk("R1 power-up recall starts", status, 3);
    chk("R5 clear phase first", nv_phase, 3);
    count_status(3, n, rd, bz);
    chk("R5 power-up recall length", n, C + PUC);
    chk("R2 reads blocked in recall", rd, 0);
    chk("R4 busy high in recall", bz, 0);
    chk("R5 recall done strobe", xfer_done, 1);
    chk("R5 recall kind", xfer_store, 0);

    // access vectors in idle
    for (int i = 0; i < 6; i++) begin
      host_ce_n = ACC_VEC[i][3]; host_we_n = ACC_VEC[i][2];
      #1;
      chk("R2 idle write enable", arr_wr_en, int'(ACC_VEC[i][1]));
      chk("R2 idle read enable", arr_rd_en, int'(ACC_VEC[i][0]));
      nedge();
    end
    chk("R3 dirty after write", dirty, 1);

    // hardware store with an in-flight write
    host_ce_n = 0; host_we_n = 0; #1;
    chk("R2 write before request", arr_wr_en, 1);
    nedge();
    hw_req_n = 0;
    nedge();
    chk("R6 grace entered", status, 1);
    chk("R7 in-flight write continues", arr_wr_en, 1);
    host_we_n = 1; #1;
    chk("R7 read in grace", arr_rd_en, 1);
    nedge();
    host_we_n = 0; #1;
    chk("R7 new write blocked in grace", arr_wr_en, 0);
    nedge();
    host_ce_n = 1; host_we_n = 1;
    count_status(1, n, rd, bz);
    chk("R6 grace length", n + 2, G);
    chk("R13 store status", status, 2);
    chk("R5 erase phase", nv_phase, 1);
    count_busy(n);
    chk("R4 busy length hw store", n, E + P);
    chk("R4 done at release", xfer_done, 1);
    chk("R4 done is store", xfer_store, 1);
    chk("R3 dirty cleared by store", dirty, 0);
    chk("R8 locked while pin low", status, 2);
    host_ce_n = 0; #1;
    chk("R8 no read while locked", arr_rd_en, 0);
    nedge(); nedge();
    chk("R8 still locked", status, 2);
    hw_req_n = 1; host_ce_n = 1;
    nedge();
    chk("R8 idle after release", status, 0);

    // hardware request while clean
    hw_req_n = 0;
    k = 0;
    repeat (4) begin nedge(); if (status != 2'd0) k++; end
    chk("R6 clean request ignored", k, 0);
    hw_req_n = 1; nedge();

    // software store while clean; command while busy dropped
    sw_cmd_valid = 1; sw_cmd_op = 2'd0;
    nedge();
    chk("R9 sw store runs clean", status, 2);
    chk("R5 sw store erase", nv_phase, 1);
    sw_cmd_op = 2'd1;
    nedge();
    sw_cmd_valid = 0;
    count_busy(n);
    chk("R4 busy length sw store", n + 1, E + P);
    chk("R4 sw store done", xfer_done, 1);
    nedge();
    chk("R9 busy command dropped", status, 0);

    // auto off, supply loss
    sw_cmd_valid = 1; sw_cmd_op = 2'd2; nedge(); sw_cmd_valid = 0;
    chk("R9 auto off", auto_en, 0);
    write_once();
    chk("R3 dirty set", dirty, 1);
    sup_ok = 0;
    nedge();
    chk("R10 no auto store when off", status, 0);
    host_ce_n = 0; host_we_n = 0; #1;
    chk("R10 write blocked low supply", arr_wr_en, 0);
    nedge();
    host_ce_n = 1; host_we_n = 1;
    sw_cmd_valid = 1; sw_cmd_op = 2'd0;
    nedge();
    sw_cmd_valid = 0;
    chk("R10 sw store blocked low supply", status, 0);
    sup_ok = 1;
    nedge();
    chk("R10 recall on supply return", status, 3);
    count_status(3, n, rd, bz);
    chk("R10 power-up copy length", n, C + PUC);
    chk("R3 dirty cleared by recall", dirty, 0);

    // auto on, automatic store, then priority of recall over sw store
    sw_cmd_valid = 1; sw_cmd_op = 2'd3; nedge(); sw_cmd_valid = 0;
    chk("R9 auto on", auto_en, 1);
    write_once();
    sup_ok = 0;
    nedge();
    chk("R10 auto store started", status, 2);
    count_busy(n);
    chk("R4 busy length auto store", n, E + P);
    chk("R4 auto store done", xfer_store, 1);
    sup_ok = 1; sw_cmd_valid = 1; sw_cmd_op = 2'd0;
    nedge();
    sw_cmd_valid = 0;
    chk("R11 recall beats sw store", status, 3);
    count_status(3, n, rd, bz);
    chk("R11 recall completes", n, C + PUC);

    // hardware beats software
    write_once();
    hw_req_n = 0; sw_cmd_valid = 1; sw_cmd_op = 2'd1;
    nedge();
    hw_req_n = 1; sw_cmd_valid = 0;
    chk("R11 hw beats sw", status, 1);
    k = 0;
    while (status != 2'd0 && k < 200) begin k++; nedge(); end
    chk("R3 clean after hw store", dirty, 0);

    // software recall with held write strobes
    host_ce_n = 0; host_we_n = 0;
    sw_cmd_valid = 1; sw_cmd_op = 2'd1;
    nedge();
    sw_cmd_valid = 0;
    chk("R2 write blocked in recall", arr_wr_en, 0);
    count_status(3, n, rd, bz);
    chk("R5 sw recall length", n, C + SWC);
    #1;
    chk("R12 held write blocked", arr_wr_en, 0);
    nedge();
    chk("R12 still blocked", arr_wr_en, 0);
    host_we_n = 1; nedge();
    host_we_n = 0; #1;
    chk("R12 new write allowed", arr_wr_en, 1);
    nedge();
    host_ce_n = 1; host_we_n = 1;
    nedge();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule